// File: doc/BRIEF.md
# Four-Channel Pulse Generator with Deferred Retune

This block produces four independent pulse-width-modulated outputs, each driven from its own counter and set up through a small synchronous register bus. Every channel has a control word that picks a power-of-two clock divider, inverts the output when asked, and chooses what the retune register will overwrite. Each channel also has a high-time (duty) value and a cycle-length (period) value.

Software configures a stopped channel by writing duty and period directly, then starts it through a global set-to-run register. To change a running channel without a glitch, software writes the channel's retune register. The value waits in a holding slot and is copied into duty or period only when the counter finishes a full period. A global stop register halts channels, and a status register shows which channels are running.

The bus has an address, a write strobe, write data and combinational read data. Offsets: run-set 0x004, run-clear 0x008, run status 0x00C. Channel n's block starts at 0x200 + 0x20·n and holds control at +0x00, duty at +0x04, period at +0x08 and retune at +0x10.

Top module: `pwm4_top`

## Requirements
- R1: After reset every channel is stopped, the status register reads 0, every output is low, and the control, duty and period registers read 0.
- R2: Duty and period keep only write-data bits [15:0], and reads return bits [31:16] as zero. The retune register reads back the last value written to it, also limited to 16 bits.
- R3: The control word stores the divider select in bits [3:0], the invert flag in bit 9 and the retune target in bit 10 (0 = duty, 1 = period). All other bits read as zero.
- R4: A write to run-set starts every channel n whose write-data bit n is 1. A write to run-clear stops every channel n whose bit n is 1. Zero bits leave their channel as it was. Status bit n is 1 exactly when channel n runs, so it reads 0x0F when all four run.
- R5: A running channel counts 0 to period−1 and repeats. Its output is high while the count is below duty. Starting a channel makes the count 0 in the first cycle after the start write.
- R6: The count advances once every 2^N clock cycles, with N the divider select. A select above 10 acts as 10.
- R7: With the invert flag set, the output is the complement of the normal waveform. A stopped channel drives the inactive level: low when the flag is clear, high when it is set.
- R8: A duty of 0 gives a constantly inactive output. A duty equal to or larger than period gives a constantly active output.
- R9: On a running channel, a retune write with target duty takes effect at the next end of period. The old duty holds until then.
- R10: A retune write with target period takes effect in the same way, at the next end of period.
- R11: Direct writes to duty or period are ignored while the channel runs.
- R12: Stopping a channel returns its count to 0. Restarting it begins a fresh period from count 0.
- R13: Only one retune value is held. A second write before the end of period replaces the first.
- R14: On a stopped channel, a held retune value is copied into its target on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 4 | One output per channel |

## Verification
The hardest case to reach from the ports is a retune that lands while a channel is running, in the middle of a period. The write has to fall in a known cycle so that the old and new values can be told apart on each side of the end of that period. The stimulus writes the config while the channel is stopped and starts it. It then drives the retune write in a chosen cycle of the first period, counted from the start write, and compares the output cycle by cycle over the next two periods. The same timing is used to send two retune writes in one period, and to send a period retune.

// File: rtl/pwm4_pkg.sv
`timescale 1ns/1ps
package pwm4_pkg;
    localparam int NUM_CH       = 4;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 12;
    localparam int VAL_W        = 16;
    localparam int PRE_W        = 4;
    localparam int MAX_PRE      = 10;

    localparam int RUN_SET_OFF  = 'h004;
    localparam int RUN_CLR_OFF  = 'h008;
    localparam int RUN_STAT_OFF = 'h00C;
    localparam int CH_BASE_OFF  = 'h200;
    localparam int CH_STRIDE    = 'h020;
    localparam int CH_CTRL_OFF  = 'h00;
    localparam int CH_DUTY_OFF  = 'h04;
    localparam int CH_PRD_OFF   = 'h08;
    localparam int CH_RETUNE_OFF = 'h10;

    localparam int INV_BIT      = 9;
    localparam int TGT_BIT      = 10;

    typedef struct packed {
        logic             tgt_prd;
        logic             inv;
        logic [PRE_W-1:0] pre;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_DUTY,
        SEL_PRD,
        SEL_RETUNE
    } ch_reg_e;

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
        logic [VAL_W-1:0] duty;
        logic [VAL_W-1:0] prd;
        logic             pend;
        logic             wrap;
        logic             inv;
    } ch_mon_t;

    function automatic logic [PRE_W-1:0] clamp_pre(input logic [PRE_W-1:0] p);
        return (int'(p) > MAX_PRE) ? PRE_W'(MAX_PRE) : p;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PRE_W-1:0] = c.pre;
        w[INV_BIT]   = c.inv;
        w[TGT_BIT]   = c.tgt_prd;
        return w;
    endfunction
endpackage

// File: rtl/pwm4_decode.sv
`timescale 1ns/1ps
module pwm4_decode
    import pwm4_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int AW   = ADDR_W
) (
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    output logic            set_we,
    output logic            clr_we,
    output logic            stat_sel,
    output logic [N_CH-1:0] ch_sel,
    output ch_reg_e         kind
);
    localparam int STRIDE_LG = $clog2(CH_STRIDE);
    localparam int IDX_W     = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam logic [AW-1:0] CH_LO = AW'(CH_BASE_OFF);
    localparam logic [AW-1:0] CH_HI = AW'(CH_BASE_OFF + N_CH * CH_STRIDE);

    logic [AW-1:0]        off;
    logic [IDX_W-1:0]     idx;
    logic [STRIDE_LG-1:0] sub;
    logic                 in_ch;

    always_comb begin
        off      = addr - CH_LO;
        idx      = off[STRIDE_LG +: IDX_W];
        sub      = off[STRIDE_LG-1:0];
        in_ch    = (addr >= CH_LO) && (addr < CH_HI);
        set_we   = wr && (addr == AW'(RUN_SET_OFF));
        clr_we   = wr && (addr == AW'(RUN_CLR_OFF));
        stat_sel = (addr == AW'(RUN_STAT_OFF));
        ch_sel   = in_ch ? (N_CH'(1) << idx) : '0;
        case (sub)
            STRIDE_LG'(CH_CTRL_OFF):   kind = SEL_CTRL;
            STRIDE_LG'(CH_DUTY_OFF):   kind = SEL_DUTY;
            STRIDE_LG'(CH_PRD_OFF):    kind = SEL_PRD;
            STRIDE_LG'(CH_RETUNE_OFF): kind = SEL_RETUNE;
            default:                   kind = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/pwm4_prescaler.sv
`timescale 1ns/1ps
module pwm4_prescaler
    import pwm4_pkg::*;
#(
    parameter int MAX_PRE_P = MAX_PRE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);
    localparam int PC_W = (MAX_PRE_P > 0) ? MAX_PRE_P : 1;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] mask;

    always_comb begin
        mask = ~({PC_W{1'b1}} << sel);
        tick = run && (pcnt_q == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) pcnt_q <= '0;
        else                     pcnt_q <= pcnt_q + PC_W'(1);
    end
endmodule

// File: rtl/pwm4_channel.sv
`timescale 1ns/1ps
module pwm4_channel
    import pwm4_pkg::*;
#(
    parameter int MAX_PRE_P = MAX_PRE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             we_ctrl,
    input  logic             we_duty,
    input  logic             we_prd,
    input  logic             we_retune,
    input  logic [VAL_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic [VAL_W-1:0] duty_q,
    output logic [VAL_W-1:0] prd_q,
    output logic [VAL_W-1:0] hold_q,
    output logic             pwm_o,
    output ch_mon_t          mon
);
    logic             tick;
    logic             last;
    logic             wrap;
    logic             apply;
    logic             pend_q;
    logic             tgt_q;
    logic [VAL_W-1:0] cnt_q;

    pwm4_prescaler #(.MAX_PRE_P(MAX_PRE_P)) pre_i (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (clamp_pre(ctrl_q.pre)),
        .tick (tick)
    );

    always_comb begin
        last  = (prd_q <= VAL_W'(1)) || (cnt_q == prd_q - VAL_W'(1));
        wrap  = tick && last;
        apply = pend_q && (wrap || !run);
        pwm_o = (run && (cnt_q < duty_q)) ^ ctrl_q.inv;
        mon   = '{cnt: cnt_q, duty: duty_q, prd: prd_q, pend: pend_q,
                  wrap: wrap, inv: ctrl_q.inv};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ctrl_q <= '0;
            duty_q <= '0;
            prd_q  <= '0;
            hold_q <= '0;
            pend_q <= 1'b0;
            tgt_q  <= 1'b0;
        end else begin
            if (!run)      cnt_q <= '0;
            else if (tick) cnt_q <= last ? '0 : cnt_q + VAL_W'(1);

            if (we_ctrl) begin
                ctrl_q.pre     <= wdata[PRE_W-1:0];
                ctrl_q.inv     <= wdata[INV_BIT];
                ctrl_q.tgt_prd <= wdata[TGT_BIT];
            end

            if (apply) begin
                if (tgt_q) prd_q  <= hold_q;
                else       duty_q <= hold_q;
            end else begin
                if (we_duty && !run) duty_q <= wdata;
                if (we_prd && !run)  prd_q  <= wdata;
            end

            if (we_retune) begin
                hold_q <= wdata;
                pend_q <= 1'b1;
                tgt_q  <= ctrl_q.tgt_prd;
            end else if (apply) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwm4_top.sv
`timescale 1ns/1ps
module pwm4_top
    import pwm4_pkg::*;
#(
    parameter int NUM_CH_P = NUM_CH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_CH_P-1:0] pwm_o
);
    logic                set_we;
    logic                clr_we;
    logic                stat_sel;
    logic [NUM_CH_P-1:0] ch_sel;
    ch_reg_e             kind;
    logic [NUM_CH_P-1:0] en_q;

    ctrl_t               ctrl_a [NUM_CH_P];
    logic [VAL_W-1:0]    duty_a [NUM_CH_P];
    logic [VAL_W-1:0]    prd_a  [NUM_CH_P];
    logic [VAL_W-1:0]    hold_a [NUM_CH_P];
    ch_mon_t [NUM_CH_P-1:0] mon_a;

    pwm4_decode #(.N_CH(NUM_CH_P), .AW(ADDR_W)) dec_i (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .stat_sel (stat_sel),
        .ch_sel   (ch_sel),
        .kind     (kind)
    );

    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (set_we) en_q <= en_q | bus_wdata[NUM_CH_P-1:0];
        else if (clr_we) en_q <= en_q & ~bus_wdata[NUM_CH_P-1:0];
    end

    for (genvar g = 0; g < NUM_CH_P; g++) begin : g_ch
        logic hit;
        assign hit = bus_wr && ch_sel[g];
        pwm4_channel ch_i (
            .clk       (clk),
            .rst       (rst),
            .run       (en_q[g]),
            .we_ctrl   (hit && (kind == SEL_CTRL)),
            .we_duty   (hit && (kind == SEL_DUTY)),
            .we_prd    (hit && (kind == SEL_PRD)),
            .we_retune (hit && (kind == SEL_RETUNE)),
            .wdata     (bus_wdata[VAL_W-1:0]),
            .ctrl_q    (ctrl_a[g]),
            .duty_q    (duty_a[g]),
            .prd_q     (prd_a[g]),
            .hold_q    (hold_a[g]),
            .pwm_o     (pwm_o[g]),
            .mon       (mon_a[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (stat_sel) bus_rdata[NUM_CH_P-1:0] = en_q;
        for (int i = 0; i < NUM_CH_P; i++) begin
            if (ch_sel[i]) begin
                case (kind)
                    SEL_CTRL:   bus_rdata = ctrl_word(ctrl_a[i]);
                    SEL_DUTY:   bus_rdata = DATA_W'(duty_a[i]);
                    SEL_PRD:    bus_rdata = DATA_W'(prd_a[i]);
                    SEL_RETUNE: bus_rdata = DATA_W'(hold_a[i]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pwm4_checker.sv
`timescale 1ns/1ps
module pwm4_checker
    import pwm4_pkg::*;
#(
    parameter int NUM_CH_P = NUM_CH
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [NUM_CH_P-1:0]    en_q,
    input logic [NUM_CH_P-1:0]    pwm_o,
    input ch_mon_t [NUM_CH_P-1:0] mon
);
    for (genvar g = 0; g < NUM_CH_P; g++) begin : g_chk
        assert_start_R4: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == ADDR_W'(RUN_SET_OFF) && bus_wdata[g]) |=> en_q[g]);

        assert_stop_R4: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == ADDR_W'(RUN_CLR_OFF) && bus_wdata[g]) |=> !en_q[g]);

        assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
            (en_q[g] && mon[g].prd != '0) |-> (mon[g].cnt < mon[g].prd));

        assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
            !en_q[g] |-> (pwm_o[g] == mon[g].inv));

        assert_zero_duty_R8: assert property (@(posedge clk) disable iff (rst)
            (en_q[g] && mon[g].duty == '0) |-> (pwm_o[g] == mon[g].inv));

        assert_duty_only_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
            (en_q[g] && !mon[g].wrap) |=> $stable(mon[g].duty));

        assert_prd_only_at_wrap_R10: assert property (@(posedge clk) disable iff (rst)
            (en_q[g] && !mon[g].wrap) |=> $stable(mon[g].prd));

        assert_stop_clears_cnt_R12: assert property (@(posedge clk) disable iff (rst)
            !en_q[g] |=> (mon[g].cnt == '0));

        assert_idle_apply_R14: assert property (@(posedge clk) disable iff (rst)
            (!en_q[g] && mon[g].pend && !(bus_wr && bus_addr ==
                ADDR_W'(CH_BASE_OFF + g * CH_STRIDE + CH_RETUNE_OFF))) |=> !mon[g].pend);
    end
endmodule

bind pwm4_top pwm4_checker #(.NUM_CH_P(NUM_CH_P)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .en_q      (en_q),
    .pwm_o     (pwm_o),
    .mon       (mon_a)
);

// File: tb/pwm4_top_tb_top.sv
`timescale 1ns/1ps
module pwm4_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;

    int checks = 0;
    int errors = 0;

    localparam logic [11:0] A_SET  = 12'h004;
    localparam logic [11:0] A_CLR  = 12'h008;
    localparam logic [11:0] A_STAT = 12'h00C;

    always #2.5 clk = ~clk;

    pwm4_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    function automatic logic [11:0] ca(input int ch, input int off);
        return 12'(32'h200 + ch * 32 + off);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] a, input logic [31:0] d, input logic w);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = w;
    endtask

    task automatic bus_wr_t(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        drive(a, d, 1'b1);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_rd_t(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        drive(a, '0, 1'b0);
        #1;
        d = bus_rdata;
    endtask

    task automatic setup(input int ch, input logic [31:0] ctrl, input int duty, input int prd);
        bus_wr_t(A_CLR, 32'(1) << ch);
        bus_wr_t(ca(ch, 0), ctrl);
        bus_wr_t(ca(ch, 4), 32'(duty));
        bus_wr_t(ca(ch, 8), 32'(prd));
    endtask

    // Called at the first sample point after the start write (count 0).
    task automatic wave_check(input string tag, input int ch, input int n, input int d,
                              input int p, input bit inv, input int cycles);
        bit bad = 0;
        logic a_f = 0, e_f = 0;
        for (int k = 0; k < cycles; k++) begin
            logic e;
            e = (((k >> n) % p) < d) ^ inv;
            if (pwm_o[ch] !== e && !bad) begin
                bad = 1; a_f = pwm_o[ch]; e_f = e;
                $display("  mismatch at cycle %0d", k);
            end
            @(negedge clk);
        end
        if (bad) chk(tag, 32'(a_f), 32'(e_f));
        else     chk(tag, 0, 0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 outputs after reset", 32'(pwm_o), 0);
        bus_rd_t(A_STAT, d);   chk("R1 status after reset", d, 0);
        bus_rd_t(ca(2, 4), d); chk("R1 duty after reset", d, 0);
        bus_rd_t(ca(1, 0), d); chk("R1 control after reset", d, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        bus_wr_t(ca(3, 4), 32'hABCD_1234);
        bus_rd_t(ca(3, 4), d); chk("R2 duty width", d, 32'h0000_1234);
        bus_wr_t(ca(3, 8), 32'h5555_FFFF);
        bus_rd_t(ca(3, 8), d); chk("R2 period width", d, 32'h0000_FFFF);
        bus_wr_t(ca(3, 16), 32'h7777_0042);
        bus_rd_t(ca(3, 16), d); chk("R2 retune readback", d, 32'h0000_0042);
        bus_wr_t(ca(2, 0), 32'hFFFF_FFFF);
        bus_rd_t(ca(2, 0), d); chk("R3 control mask", d, 32'h0000_060F);
        bus_wr_t(ca(2, 0), 32'h0000_0205);
        bus_rd_t(ca(2, 0), d); chk("R3 control fields", d, 32'h0000_0205);
        bus_wr_t(ca(2, 0), 0);
        bus_wr_t(ca(3, 4), 0);
        bus_wr_t(ca(3, 8), 0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        bus_wr_t(A_SET, 32'h5); bus_rd_t(A_STAT, d); chk("R4 start 0 and 2", d, 32'h5);
        bus_wr_t(A_SET, 32'h2); bus_rd_t(A_STAT, d); chk("R4 start 1 keeps others", d, 32'h7);
        bus_wr_t(A_CLR, 32'h4); bus_rd_t(A_STAT, d); chk("R4 stop 2 only", d, 32'h3);
        bus_wr_t(A_SET, 32'h0); bus_rd_t(A_STAT, d); chk("R4 zero write no effect", d, 32'h3);
        bus_wr_t(A_SET, 32'hF); bus_rd_t(A_STAT, d); chk("R4 all running", d, 32'hF);
        bus_wr_t(A_CLR, 32'hF); bus_rd_t(A_STAT, d); chk("R4 all stopped", d, 32'h0);
    endtask

    task automatic t_wave;
        setup(1, 0, 3, 7);
        bus_wr_t(A_SET, 32'h2);
        wave_check("R5 duty 3 period 7", 1, 0, 3, 7, 0, 21);
        setup(2, 0, 1, 2);
        bus_wr_t(A_SET, 32'h4);
        wave_check("R5 duty 1 period 2", 2, 0, 1, 2, 0, 8);
        bus_wr_t(A_CLR, 32'h6);
    endtask

    task automatic t_prescale;
        setup(0, 32'h2, 1, 3);
        bus_wr_t(A_SET, 32'h1);
        wave_check("R6 divide by 4", 0, 2, 1, 3, 0, 30);
        setup(3, 32'hF, 1, 2);
        bus_wr_t(A_SET, 32'h8);
        wave_check("R6 select above 10 clamps", 3, 10, 1, 2, 0, 1030);
        bus_wr_t(A_CLR, 32'h9);
    endtask

    task automatic t_polarity;
        setup(2, 32'h200, 2, 4);
        #1 chk("R7 stopped inverted level", 32'(pwm_o[2]), 1);
        bus_wr_t(A_SET, 32'h4);
        wave_check("R7 inverted waveform", 2, 0, 2, 4, 1, 12);
        bus_wr_t(A_CLR, 32'h4);
        chk("R7 inverted level after stop", 32'(pwm_o[2]), 1);
        bus_wr_t(ca(2, 0), 0);
    endtask

    task automatic t_extremes;
        setup(1, 0, 0, 4);
        bus_wr_t(A_SET, 32'h2);
        wave_check("R8 zero duty", 1, 0, 0, 4, 0, 10);
        setup(1, 0, 9, 4);
        bus_wr_t(A_SET, 32'h2);
        wave_check("R8 duty above period", 1, 0, 9, 4, 0, 10);
        bus_wr_t(A_CLR, 32'h2);
    endtask

    // Runs a retune scenario on channel 0, period 5, duty 2, divider 1.
    task automatic t_retune(input string tag, input logic [31:0] ctrl,
                            input int v1, input int v2, input int nd, input int np);
        bit bad = 0;
        logic a_f = 0, e_f = 0;
        setup(0, ctrl, 2, 5);
        bus_wr_t(A_SET, 32'h1);
        for (int k = 0; k < 15; k++) begin
            logic e;
            if (k < 5) e = (k < 2);
            else       e = (((k - 5) % np) < nd);
            if (pwm_o[0] !== e && !bad) begin
                bad = 1; a_f = pwm_o[0]; e_f = e;
                $display("  mismatch at cycle %0d", k);
            end
            if (k == 1) drive(ca(0, 16), 32'(v1), 1'b1);
            if (k == 2) begin
                if (v2 >= 0) drive(ca(0, 16), 32'(v2), 1'b1);
                else         bus_wr = 1'b0;
            end
            if (k == 3) bus_wr = 1'b0;
            @(negedge clk);
        end
        if (bad) chk(tag, 32'(a_f), 32'(e_f));
        else     chk(tag, 0, 0);
    endtask

    task automatic t_direct_ignored;
        logic [31:0] d;
        bus_wr_t(ca(0, 4), 32'h1);
        bus_rd_t(ca(0, 4), d); chk("R11 duty write ignored while running", d, 4);
        bus_wr_t(ca(0, 8), 32'h9);
        bus_rd_t(ca(0, 8), d); chk("R11 period write ignored while running", d, 5);
    endtask

    task automatic t_restart;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        bus_wr_t(A_CLR, 32'h1);
        chk("R12 output low after stop", 32'(pwm_o[0]), 0);
        bus_rd_t(A_STAT, d); chk("R12 status after stop", d, 0);
        repeat (3) @(negedge clk);
        bus_wr_t(A_SET, 32'h1);
        wave_check("R12 restart from count 0", 0, 0, 4, 5, 0, 10);
        bus_wr_t(A_CLR, 32'h1);
    endtask

    task automatic t_stopped_retune;
        logic [31:0] d;
        bus_wr_t(ca(0, 0), 0);
        bus_wr_t(ca(0, 16), 32'h3);
        @(negedge clk);
        bus_rd_t(ca(0, 4), d); chk("R14 stopped retune copied to duty", d, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_enable();
        t_wave();
        t_prescale();
        t_polarity();
        t_extremes();
        t_retune("R9 duty retune at end of period", 32'h0, 4, -1, 4, 5);
        t_retune("R10 period retune at end of period", 32'h400, 3, -1, 2, 3);
        t_retune("R13 second retune replaces first", 32'h0, 1, 4, 4, 5);
        t_direct_ignored();
        t_restart();
        t_stopped_retune();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule